// File: doc/BRIEF.md
# Sorted-Table Hash Match Engine

This block takes a batch of sixteen hash values and looks each one up in a table of target hashes. The table is kept in on-chip memory and sorted in ascending order. The lookup is a binary search, so the cost for each key grows with the logarithm of the table size, not with the table size. Software first writes the sorted targets into the table one entry per cycle. It then drives the number of valid entries on a count input. Only entries with an index below that count take part in a search.

A batch is taken in one cycle. The block then works through the slots in order. For every key found in the table, it emits a one-cycle match pulse carrying the slot number and the table index of the hit. When the sixteenth slot is finished it pulses batch-done and raises ready again. The keys are held inside the block while the search runs, so the upstream hash pipeline can compute the next batch at the same time.

A table of up to 511 entries needs at most nine probes per key. Tables of 512 to 1023 entries need a tenth probe, which lengthens the batch time by about a tenth.

Top module: `hash_bsearch_cmp`

## Requirements
- R1: The table is written through `tbl_wr_en`/`tbl_wr_addr`/`tbl_wr_data`, one entry per cycle. Valid addresses are 0 to 1022, so the table holds at most 1023 entries.
- R2: A batch is accepted on a rising clock edge where `ready` and `batch_valid` are both high. The key for slot s occupies bits `[s*HASH_W +: HASH_W]` of `batch_keys`. With a non-zero count, `ready` is low in the cycle after acceptance.
- R3: The search covers only entries 0 to count-1, which are taken as sorted in ascending unsigned order. An entry at an index of count or above never produces a match.
- R4: Each slot whose key equals a table entry produces exactly one `match_valid` pulse, carrying that slot number on `match_slot` and the entry's index on `match_index`. A slot whose key is absent produces no pulse.
- R5: Match pulses within a batch appear in strictly ascending slot order.
- R6: After all sixteen slots are finished, `batch_done` is high for one cycle. `ready` goes high in that same cycle.
- R7: From the acceptance edge, `batch_done` rises within 16*(2*S+1)+1 cycles, where S = ceil(log2(count+1)). This gives S ≤ 9 for counts up to 511 and S = 10 for counts from 512 to 1023.
- R8: `batch_valid` while `ready` is low is ignored. The held keys and that batch's results are unchanged, and no extra `batch_done` follows.
- R9: With a count of zero, an accepted batch produces no matches. `batch_done` is high in the cycle right after acceptance, and `ready` never drops.
- R10: After reset, `ready` is 1 and `match_valid` and `batch_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | IDX_W | Table write index |
| tbl_wr_data | input | HASH_W | Table write value |
| tbl_count | input | IDX_W | Number of valid sorted entries, sampled at acceptance |
| batch_valid | input | 1 | A batch of keys is offered |
| batch_keys | input | BATCH*HASH_W | Packed keys, slot 0 in the low bits |
| ready | output | 1 | Idle and able to accept a batch |
| match_valid | output | 1 | One-cycle match pulse |
| match_slot | output | $clog2(BATCH) | Slot of the matching key |
| match_index | output | IDX_W | Table index of the hit |
| batch_done | output | 1 | One-cycle pulse when the batch is finished |

## Verification
The hardest case to reach from the ports is a batch offered while a search is running. A faulty design would quietly take it and overwrite the held keys. To reach it, the stimulus raises `batch_valid` for one cycle partway through a batch, with different keys that all hit. The bench then checks that the reported matches still follow the original keys and that only one `batch_done` appears. Probe-count limits are exercised by reusing a single 1023-entry table with counts of 1, 10, 511, 512 and 1023. Each batch's completion time is checked against the logarithmic bound. Keys placed just past the count boundary must miss.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROBE,
    ST_CMP
  } srch_state_t;
endpackage

// File: rtl/bsc_table_ram.sv
module bsc_table_ram #(
  parameter int HASH_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [HASH_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [HASH_W-1:0] rd_data
);
  localparam int SLOTS = 1 << IDX_W;

  logic [HASH_W-1:0] mem [SLOTS];

  // Single write port, single registered read port: block RAM friendly
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  AST_WR_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr != {IDX_W{1'b1}})); // R1
endmodule

// File: rtl/bsc_batch_hold.sv
module bsc_batch_hold #(
  parameter int HASH_W = 32,
  parameter int BATCH  = 16,
  localparam int SLOT_W = $clog2(BATCH)
) (
  input  logic                    clk,
  input  logic                    load,
  input  logic [BATCH*HASH_W-1:0] keys_in,
  input  logic [SLOT_W-1:0]       sel,
  output logic [HASH_W-1:0]       key_out
);
  logic [HASH_W-1:0] held [BATCH];

  for (genvar s = 0; s < BATCH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (load) held[s] <= keys_in[s*HASH_W +: HASH_W];
    end
  end

  assign key_out = held[sel];
endmodule

// File: rtl/bsc_search_ctrl.sv
module bsc_search_ctrl
  import bsc_pkg::*;
#(
  parameter int HASH_W = 32,
  parameter int IDX_W  = 10,
  parameter int BATCH  = 16,
  localparam int SLOT_W = $clog2(BATCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              batch_valid,
  input  logic [IDX_W-1:0]  count,
  input  logic [HASH_W-1:0] key,
  input  logic [HASH_W-1:0] rd_data,
  output logic [IDX_W-1:0]  rd_addr,
  output logic [SLOT_W-1:0] sel,
  output logic              load,
  output logic              ready,
  output logic              match_valid,
  output logic [SLOT_W-1:0] match_slot,
  output logic [IDX_W-1:0]  match_index,
  output logic              done
);
  srch_state_t       state;
  logic [IDX_W-1:0]  lo, hi, mid_q, cnt_q;
  logic [SLOT_W-1:0] slot;
  logic [IDX_W:0]    span_sum;
  logic              last_slot;

  assign span_sum  = {1'b0, lo} + {1'b0, hi};
  assign rd_addr   = span_sum[IDX_W:1];
  assign last_slot = (slot == SLOT_W'(BATCH - 1));
  assign load      = (state == ST_IDLE) && batch_valid;
  assign sel       = slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      ready       <= 1'b1;
      done        <= 1'b0;
      match_valid <= 1'b0;
      match_slot  <= '0;
      match_index <= '0;
      lo          <= '0;
      hi          <= '0;
      mid_q       <= '0;
      cnt_q       <= '0;
      slot        <= '0;
    end else begin
      match_valid <= 1'b0;
      done        <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (batch_valid) begin
            cnt_q <= count;
            slot  <= '0;
            lo    <= '0;
            hi    <= count;
            if (count == '0) begin
              done <= 1'b1;
            end else begin
              state <= ST_PROBE;
              ready <= 1'b0;
            end
          end
        end
        ST_PROBE: begin
          if (lo >= hi) begin
            // interval empty: key absent, move on
            if (last_slot) begin
              state <= ST_IDLE;
              ready <= 1'b1;
              done  <= 1'b1;
            end else begin
              slot <= slot + 1'b1;
              lo   <= '0;
              hi   <= cnt_q;
            end
          end else begin
            mid_q <= rd_addr;
            state <= ST_CMP;
          end
        end
        ST_CMP: begin
          if (rd_data == key) begin
            match_valid <= 1'b1;
            match_slot  <= slot;
            match_index <= mid_q;
            if (last_slot) begin
              state <= ST_IDLE;
              ready <= 1'b1;
              done  <= 1'b1;
            end else begin
              slot  <= slot + 1'b1;
              lo    <= '0;
              hi    <= cnt_q;
              state <= ST_PROBE;
            end
          end else begin
            if (key < rd_data) hi <= mid_q;
            else               lo <= mid_q + 1'b1;
            state <= ST_PROBE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_INTERVAL_ORDERED: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (lo <= hi && hi <= cnt_q)); // R3
  AST_PROBE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CMP) |-> (mid_q < cnt_q)); // R3
  AST_MATCH_BELOW_COUNT: assert property (@(posedge clk) disable iff (rst)
    match_valid |-> (match_index < cnt_q)); // R3
  AST_READY_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> done); // R6
  AST_EMPTY_TABLE_DONE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && batch_valid && count == '0) |=> (done && ready && !match_valid)); // R9
endmodule

// File: rtl/hash_bsearch_cmp.sv
module hash_bsearch_cmp #(
  parameter int HASH_W = 32,
  parameter int IDX_W  = 10,
  parameter int BATCH  = 16,
  localparam int SLOT_W = $clog2(BATCH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tbl_wr_en,
  input  logic [IDX_W-1:0]        tbl_wr_addr,
  input  logic [HASH_W-1:0]       tbl_wr_data,
  input  logic [IDX_W-1:0]        tbl_count,
  input  logic                    batch_valid,
  input  logic [BATCH*HASH_W-1:0] batch_keys,
  output logic                    ready,
  output logic                    match_valid,
  output logic [SLOT_W-1:0]       match_slot,
  output logic [IDX_W-1:0]        match_index,
  output logic                    batch_done
);
  logic [IDX_W-1:0]  rd_addr;
  logic [HASH_W-1:0] rd_data;
  logic [HASH_W-1:0] cur_key;
  logic [SLOT_W-1:0] sel;
  logic              load;

  bsc_table_ram #(.HASH_W(HASH_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst), .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr),
    .wr_data(tbl_wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  bsc_batch_hold #(.HASH_W(HASH_W), .BATCH(BATCH)) u_hold (
    .clk(clk), .load(load), .keys_in(batch_keys), .sel(sel), .key_out(cur_key)
  );

  bsc_search_ctrl #(.HASH_W(HASH_W), .IDX_W(IDX_W), .BATCH(BATCH)) u_ctrl (
    .clk(clk), .rst(rst), .batch_valid(batch_valid), .count(tbl_count),
    .key(cur_key), .rd_data(rd_data), .rd_addr(rd_addr), .sel(sel),
    .load(load), .ready(ready), .match_valid(match_valid),
    .match_slot(match_slot), .match_index(match_index), .done(batch_done)
  );
endmodule

// File: tb/hash_bsearch_cmp_test.sv
module hash_bsearch_cmp_test;
  localparam int HW = 32;
  localparam int IW = 10;
  localparam int NB = 16;
  localparam int NT = 1023;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tbl_wr_en = 1'b0;
  logic [IW-1:0] tbl_wr_addr = '0;
  logic [HW-1:0] tbl_wr_data = '0;
  logic [IW-1:0] tbl_count = '0;
  logic batch_valid = 1'b0;
  logic [NB*HW-1:0] batch_keys = '0;
  logic ready, match_valid, batch_done;
  logic [3:0] match_slot;
  logic [IW-1:0] match_index;

  always #10 clk = ~clk; // 50 MHz

  hash_bsearch_cmp uut (
    .clk(clk), .rst(rst), .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
    .tbl_wr_data(tbl_wr_data), .tbl_count(tbl_count), .batch_valid(batch_valid),
    .batch_keys(batch_keys), .ready(ready), .match_valid(match_valid),
    .match_slot(match_slot), .match_index(match_index), .batch_done(batch_done)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [HW-1:0] mdl [NT];

  typedef struct packed {
    logic [IW-1:0] cnt;
    logic [HW-1:0] base;
    logic [HW-1:0] step;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{10'd10,   32'h0000_1000,            32'd7},           // hits 0..9, misses past count
    '{10'd1023, 32'h0000_1000,            32'd420},         // sparse hits over full table
    '{10'd1023, 32'h0000_1001,            32'd7},           // all between entries
    '{10'd1,    32'h0000_0FF0,            32'd8},           // single entry, slot 2 hits
    '{10'd511,  32'h0000_1000 + 32'd3514, 32'd7},           // idx 502.., edge of count 511
    '{10'd512,  32'h0000_1000 + 32'd3514, 32'd7},           // one more probe level
    '{10'd1023, 32'h0000_0000,            32'h0800_0000}    // below min and above max
  };

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic write_entry(input int idx, input logic [HW-1:0] val);
    @(negedge clk);
    tbl_wr_en = 1'b1;
    tbl_wr_addr = IW'(idx);
    tbl_wr_data = val;
    mdl[idx] = val;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic run_batch(input int cnt, input logic [HW-1:0] base,
                           input logic [HW-1:0] step, input bit poke);
    logic [NB*HW-1:0] orig;
    bit   got_hit [NB];
    int   got_idx [NB];
    int   last_slot;
    int   cyc;
    int   bound;
    bit   exp_hit;
    int   exp_idx;
    for (int s = 0; s < NB; s++) begin
      orig[s*HW +: HW] = base + HW'(s) * step;
      got_hit[s] = 0;
      got_idx[s] = 0;
    end
    last_slot = -1;
    @(negedge clk);
    tbl_count = IW'(cnt);
    batch_keys = orig;
    batch_valid = 1'b1;
    @(posedge clk); // acceptance edge
    @(negedge clk);
    batch_valid = 1'b0;
    cyc = 1;
    if (cnt != 0) chk(ready == 1'b0, $sformatf("R2 ready after accept: got %0d expected 0", ready));
    else chk(ready == 1'b1, $sformatf("R9 ready with empty table: got %0d expected 1", ready));
    while (!batch_done && cyc < 20000) begin
      if (match_valid) begin
        chk(int'(match_slot) > last_slot,
            $sformatf("R5 slot order: got %0d after %0d expected greater", match_slot, last_slot));
        last_slot = int'(match_slot);
        got_hit[match_slot] = 1;
        got_idx[match_slot] = int'(match_index);
      end
      if (poke && cyc == 3) begin
        chk(ready == 1'b0, $sformatf("R8 ready mid-batch: got %0d expected 0", ready));
        for (int s = 0; s < NB; s++) batch_keys[s*HW +: HW] = mdl[0];
        batch_valid = 1'b1;
      end
      if (poke && cyc == 4) batch_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    if (match_valid) begin
      chk(int'(match_slot) > last_slot,
          $sformatf("R5 slot order: got %0d after %0d expected greater", match_slot, last_slot));
      got_hit[match_slot] = 1;
      got_idx[match_slot] = int'(match_index);
    end
    bound = 16 * (2 * $clog2(cnt + 1) + 1) + 1;
    if (cnt == 0)
      chk(cyc == 1, $sformatf("R9 done latency: got %0d expected 1", cyc));
    else
      chk(cyc <= bound, $sformatf("R7 latency count=%0d: got %0d expected <= %0d", cnt, cyc, bound));
    chk(ready == 1'b1, $sformatf("R6 ready with done: got %0d expected 1", ready));
    for (int s = 0; s < NB; s++) begin
      exp_hit = 0;
      exp_idx = 0;
      for (int i = 0; i < cnt; i++)
        if (mdl[i] == orig[s*HW +: HW]) begin
          exp_hit = 1;
          exp_idx = i;
        end
      chk(got_hit[s] == exp_hit && (!exp_hit || got_idx[s] == exp_idx),
          $sformatf("R4/R3 count=%0d slot %0d: got hit=%0d idx=%0d expected hit=%0d idx=%0d",
                    cnt, s, got_hit[s], got_idx[s], exp_hit, exp_idx));
    end
    @(negedge clk);
    chk(batch_done == 1'b0, $sformatf("R6 done width: got %0d expected 0", batch_done));
    if (poke) begin
      repeat (40) begin
        @(negedge clk);
        if (batch_done || match_valid)
          chk(1'b0, $sformatf("R8 extra activity after ignored offer: done=%0d match=%0d expected 0",
                              batch_done, match_valid));
      end
      chk(ready == 1'b1, $sformatf("R8 ready after ignored offer: got %0d expected 1", ready));
    end
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ready == 1'b1 && match_valid == 1'b0 && batch_done == 1'b0,
        $sformatf("R10 reset state: got ready=%0d match=%0d done=%0d expected 1 0 0",
                  ready, match_valid, batch_done));
    rst = 1'b0;

    // R1: fill the full 1023-entry sorted table
    for (int i = 0; i < NT; i++) begin
      @(negedge clk);
      tbl_wr_en = 1'b1;
      tbl_wr_addr = IW'(i);
      tbl_wr_data = 32'h0000_1000 + 32'(i) * 32'd7;
      mdl[i] = tbl_wr_data;
    end
    @(negedge clk);
    tbl_wr_en = 1'b0;

    for (int v = 0; v < NV; v++)
      run_batch(int'(VECS[v].cnt), VECS[v].base, VECS[v].step, 1'b0);

    // R9: empty table
    run_batch(0, 32'h0000_1000, 32'd7, 1'b0);
    // R8: offer during search is ignored
    run_batch(10, 32'h0000_1000, 32'd7, 1'b1);
    // R1: rewrite a small table and search it
    write_entry(0, 32'h50);
    write_entry(1, 32'h60);
    write_entry(2, 32'h70);
    write_entry(3, 32'h80);
    run_batch(4, 32'h50, 32'h10, 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule